// File: doc/BRIEF.md
# External Interrupt Edge/Level Controller

This block turns four external interrupt pins into latched, prioritised interrupt requests for a small 8-bit CPU core. Each pin is synchronised through two flops. It is then compared with its previous sample to find edges. The result either sets a sticky request flag or, in level mode, makes the flag follow the pin. Pins 0 and 1 offer single-edge and level detection. Pins 2 and 3 offer single-edge and both-edge detection. Pin 3 also passes through a pulse-width noise filter whose sampling rate is selectable.

Software programs modes, enables, the filter rate and the timer-count sources through a small register port. It clears flags by writing ones. The CPU sees one request line with a vector address, which belongs to the lowest-numbered enabled pending pin. The CPU accepts the request by pulsing the acknowledge input. Edges detected on pins 2 and 3 can also drive a one-cycle event strobe into a timer.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all enables, flags, count-source bits and the filter rate bit read 0, every pin is in falling-edge mode, `irq_req` is 0, `irq_vector` is 0 and `tmr_event` is 0.
- R2: `irq_req` is 1 exactly when some pin has both its flag and its enable set. While it is 1, `irq_vector` is 03h, 0Bh, 13h or 1Bh for pin 0, 1, 2 or 3. While it is 0, `irq_vector` is 0.
- R3: Pins 0 and 1 take a 2-bit mode: 00 falling edge, 01 rising edge, 10 low level, 11 high level. In a level mode the flag follows the active level, and writing 1 to clear it has no effect while the level persists.
- R4: Pins 2 and 3 take a 2-bit mode: 00 falling edge, 01 rising edge, 10 or 11 both edges.
- R5: In edge modes a detected edge sets the pin's flag, and the flag stays set until it is cleared. Writing 1 to bit i at address 2 clears flag i. An edge detected in the same cycle as the clear takes precedence.
- R6: When several enabled flags are pending, the lowest-numbered pin supplies the vector. A cycle with `irq_ack` high and `irq_req` high clears that pin's edge-mode flag, and the next pending pin then supplies the vector.
- R7: A pin whose enable is 0 still sets its flag, which reads back at address 2, but it never raises `irq_req`.
- R8: With the filter rate bit at 0, pin 3 takes a new level only after it has been sampled at that level on 2 consecutive clocks. A 1-cycle pulse is therefore discarded and a 2-cycle pulse is detected.
- R9: With the filter rate bit at 1, pin 3 is sampled once every 16 clocks and needs 2 consecutive samples at the new level. A pulse shorter than 16 cycles is discarded and one of 32 cycles or more is detected.
- R10: Address 1 bit 5 lets pin 2 drive `tmr_event`, and bit 6 lets pin 3 drive it. Each edge detected under that pin's mode gives one 1-cycle `tmr_event` pulse, whether or not the pin is enabled.
- R11: The register map is as follows. Address 0 holds the modes, with pin i in bits [2i+1:2i]. Address 1 holds the enables in bits [3:0], the filter rate in bit 4 and the count sources in bits [6:5]. Address 2 holds the flags in bits [3:0]. Every other read bit and address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin | input | 4 | Asynchronous external interrupt pins, idle high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 8 | Vector address of the winning pin |
| irq_ack | input | 1 | CPU acceptance of the current request |
| tmr_event | output | 1 | One-cycle timer count strobe |

## Verification
The assertions assume that `irq_pin` changes slowly enough for the synchroniser. They also assume that `irq_ack` is pulsed only while a request is visible, and that software does not rewrite the filter rate while a pulse is being qualified. The bench drives every pin change and register access on the falling clock edge. It holds each pulse for a whole number of cycles, and changes the filter rate only when pin 3 has been idle for many cycles. It waits several cycles after every pin change before sampling, so that the two synchroniser stages, the filter and the flag register have all settled.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int         FILT_NEED = 2,
  parameter int         SLOW_DIV  = 16,
  parameter logic [7:0] VEC_BASE  = 8'h03,
  parameter logic [7:0] VEC_STEP  = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_pin,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_req,
  output logic [7:0] irq_vector,
  input  logic       irq_ack,
  output logic       tmr_event
);
  localparam int NPIN = 4;
  localparam int PW   = $clog2(SLOW_DIV);
  localparam int FW   = $clog2(FILT_NEED + 1);

  logic [7:0]      mode_q;
  logic [3:0]      en_q, flag_q, flag_nxt;
  logic            rate_q;
  logic [1:0]      cnt_en_q;
  logic [3:0]      s1, s2, prev, det, rise, fall;
  logic [3:0]      edge_ev, lvl_mode, lvl_act, pend, clr_w, clr_ack;
  logic            filt, tick;
  logic [PW-1:0]   pre;
  logic [FW-1:0]   fcnt;
  logic [1:0]      win;
  logic            unused_wbit;

  assign unused_wbit = reg_wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      en_q     <= '0;
      rate_q   <= 1'b0;
      cnt_en_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: mode_q <= reg_wdata;
        2'd1: {cnt_en_q, rate_q, en_q} <= reg_wdata[6:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = mode_q;
      2'd1:    reg_rdata = {1'b0, cnt_en_q, rate_q, en_q};
      2'd2:    reg_rdata = {4'b0, flag_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= '1;
      s2   <= '1;
      prev <= '1;
      pre  <= '0;
    end else begin
      s1   <= irq_pin;
      s2   <= s1;
      prev <= det;
      pre  <= pre + 1'b1;
    end
  end

  assign tick = !rate_q || (pre == PW'(SLOW_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt <= 1'b1;
      fcnt <= '0;
    end else if (tick) begin
      if (s2[3] == filt) begin
        fcnt <= '0;
      end else if (fcnt == FW'(FILT_NEED - 1)) begin
        filt <= s2[3];
        fcnt <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assign det  = {filt, s2[2:0]};
  assign rise = det & ~prev;
  assign fall = ~det & prev;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [1:0] m;
    assign m = mode_q[2*i +: 2];
    if (i < 2) begin : g_lvl
      assign edge_ev[i]  = ((m == 2'b00) && fall[i]) || ((m == 2'b01) && rise[i]);
      assign lvl_mode[i] = m[1];
      assign lvl_act[i]  = m[0] ? det[i] : ~det[i];

      AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_mode[i] && lvl_act[i]) |=> flag_q[i]); // R3
    end else begin : g_edge
      assign edge_ev[i]  = m[1] ? (rise[i] || fall[i]) : (m[0] ? rise[i] : fall[i]);
      assign lvl_mode[i] = 1'b0;
      assign lvl_act[i]  = 1'b0;
    end

    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd2 && reg_wdata[i] && !lvl_mode[i] && !edge_ev[i])
      |=> !flag_q[i]); // R5
  end

  assign pend    = flag_q & en_q;
  assign irq_req = |pend;

  always_comb begin
    win = 2'd0;
    for (int i = NPIN - 1; i >= 0; i--)
      if (pend[i]) win = 2'(i);
  end

  assign irq_vector = irq_req ? (VEC_BASE + (VEC_STEP * {6'd0, win})) : 8'h00;
  assign clr_w      = (reg_we && reg_addr == 2'd2) ? reg_wdata[3:0] : 4'b0;
  assign clr_ack    = (irq_ack && irq_req) ? (4'b0001 << win) : 4'b0;

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      if (lvl_mode[i])                 flag_nxt[i] = lvl_act[i];
      else if (edge_ev[i])             flag_nxt[i] = 1'b1;
      else if (clr_w[i] || clr_ack[i]) flag_nxt[i] = 1'b0;
      else                             flag_nxt[i] = flag_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_nxt;
  end

  assign tmr_event = (cnt_en_q[0] && edge_ev[2]) || (cnt_en_q[1] && edge_ev[3]);

  AST_VEC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector[2:0] == 3'b011 && irq_vector[7:5] == 3'b000)); // R2
  AST_PRIO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && en_q[0]) |-> (irq_vector == VEC_BASE)); // R6
  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 4'b0) |-> !irq_req); // R7
  AST_FILT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> $past(tick)); // R8
  AST_EVENT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_event |-> (cnt_en_q != 2'b00)); // R10
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_pin = 4'hF;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic [7:0] irq_vector;
  logic       irq_ack = 1'b0;
  logic       tmr_event;
  int checks = 0;
  int errors = 0;
  int ev_cnt = 0;

  always #2 clk = ~clk;

  ext_irq_ctrl uut (.*);

  always @(negedge clk) if (tmr_event) ev_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic pin_pulse(input int p, input int len);
    @(negedge clk);
    irq_pin[p] = 1'b0;
    cyc(len);
    irq_pin[p] = 1'b1;
  endtask

  task automatic t_reset;
    rd_chk(2'd0, 8'h00, "R1 mode");
    rd_chk(2'd1, 8'h00, "R1 ctrl");
    rd_chk(2'd2, 8'h00, "R1 flags");
    chk(!irq_req && irq_vector == 8'h00 && !tmr_event, "R1 outputs", {irq_req, irq_vector}, 0);
  endtask

  task automatic t_fall_default;
    wr(2'd1, 8'h01);
    pin_pulse(0, 3);
    cyc(6);
    chk(irq_req && irq_vector == 8'h03, "R2 vector pin0", irq_vector, 8'h03);
    rd_chk(2'd2, 8'h01, "R5 flag sticky");
    wr(2'd2, 8'h01);
    cyc(1);
    chk(!irq_req, "R5 w1c clears", irq_req, 0);
  endtask

  task automatic t_rise;
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h02);
    @(negedge clk) irq_pin[1] = 1'b0;
    cyc(6);
    chk(!irq_req, "R3 falling ignored in rising mode", irq_req, 0);
    irq_pin[1] = 1'b1;
    cyc(6);
    chk(irq_req && irq_vector == 8'h0B, "R3 rising detected", irq_vector, 8'h0B);
    wr(2'd2, 8'h0F);
  endtask

  task automatic t_level;
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h01);
    @(negedge clk) irq_pin[0] = 1'b0;
    cyc(6);
    rd_chk(2'd2, 8'h01, "R3 low level flag");
    wr(2'd2, 8'h01);
    cyc(2);
    rd_chk(2'd2, 8'h01, "R3 w1c ignored while level held");
    irq_pin[0] = 1'b1;
    cyc(6);
    rd_chk(2'd2, 8'h00, "R3 flag follows level release");
    wr(2'd0, 8'h03);
    cyc(2);
    chk(irq_req && irq_vector == 8'h03, "R3 high level", irq_vector, 8'h03);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0F);
    cyc(1);
    chk(!irq_req, "R3 cleared after leaving level mode", irq_req, 0);
  endtask

  task automatic t_both;
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h04);
    @(negedge clk) irq_pin[2] = 1'b0;
    cyc(6);
    chk(irq_req && irq_vector == 8'h13, "R4 both: falling", irq_vector, 8'h13);
    wr(2'd2, 8'h04);
    cyc(2);
    irq_pin[2] = 1'b1;
    cyc(6);
    chk(irq_req && irq_vector == 8'h13, "R4 both: rising", irq_vector, 8'h13);
    wr(2'd2, 8'h0F);
  endtask

  task automatic t_mask;
    wr(2'd1, 8'h00);
    pin_pulse(2, 3);
    cyc(6);
    rd_chk(2'd2, 8'h04, "R7 flag sets while disabled");
    chk(!irq_req, "R7 no request while disabled", irq_req, 0);
    wr(2'd2, 8'h0F);
  endtask

  task automatic t_prio;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h0A);
    @(negedge clk) begin irq_pin[1] = 1'b0; irq_pin[3] = 1'b0; end
    cyc(8);
    chk(irq_vector == 8'h0B, "R6 lowest pin wins", irq_vector, 8'h0B);
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
    chk(irq_req && irq_vector == 8'h1B, "R6 ack passes to next", irq_vector, 8'h1B);
    rd_chk(2'd2, 8'h08, "R6 ack cleared winner only");
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
    chk(!irq_req, "R6 second ack", irq_req, 0);
    irq_pin[1] = 1'b1; irq_pin[3] = 1'b1;
    cyc(8);
    rd_chk(2'd2, 8'h00, "R6 rising ignored in falling mode");
  endtask

  task automatic t_filt_fast;
    wr(2'd1, 8'h08);
    pin_pulse(3, 1);
    cyc(8);
    chk(!irq_req, "R8 1-cycle glitch rejected", irq_req, 0);
    pin_pulse(3, 2);
    cyc(8);
    chk(irq_req && irq_vector == 8'h1B, "R8 2-cycle pulse accepted", irq_vector, 8'h1B);
    wr(2'd2, 8'h0F);
  endtask

  task automatic t_filt_slow;
    wr(2'd1, 8'h18);
    cyc(40);
    pin_pulse(3, 10);
    cyc(40);
    chk(!irq_req, "R9 10-cycle pulse rejected at slow rate", irq_req, 0);
    pin_pulse(3, 40);
    cyc(40);
    chk(irq_req, "R9 40-cycle pulse accepted at slow rate", irq_req, 1);
    wr(2'd2, 8'h0F);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_event;
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h20);
    cyc(2);
    ev_cnt = 0;
    pin_pulse(2, 6);
    cyc(6);
    chk(ev_cnt == 2, "R10 pin2 both edges give two strobes", ev_cnt, 2);
    wr(2'd1, 8'h40);
    ev_cnt = 0;
    pin_pulse(2, 6);
    cyc(6);
    chk(ev_cnt == 0, "R10 pin2 source disabled", ev_cnt, 0);
    pin_pulse(3, 6);
    cyc(8);
    chk(ev_cnt == 1, "R10 pin3 falling gives one strobe", ev_cnt, 1);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h0F);
  endtask

  task automatic t_regs;
    wr(2'd0, 8'hA5);
    rd_chk(2'd0, 8'hA5, "R11 mode readback");
    wr(2'd1, 8'hFF);
    rd_chk(2'd1, 8'h7F, "R11 ctrl readback");
    rd_chk(2'd3, 8'h00, "R11 unused address");
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0F);
    rd_chk(2'd2, 8'h00, "R11 flags clear");
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    t_reset;
    t_fall_default;
    t_rise;
    t_level;
    t_both;
    t_mask;
    t_prio;
    t_filt_fast;
    t_filt_slow;
    t_event;
    t_regs;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule